// File: doc/BRIEF.md
# Quadrature-Capable Timer Group with Auxiliary Reload

The block holds one 16-bit core timer and two 16-bit auxiliary timers. Each timer picks one of four counting modes: prescaled clock, prescaled clock qualified by a gate pin, rising edges on an external pin, or four-fold decoding of a two-phase position encoder. The first pin of each timer (`tin_i`) carries the clock, gate or encoder phase A. The second pin (`tud_i`) carries the run-time direction or encoder phase B. Every external pin passes through a two-flop synchroniser, and edges are taken from the synchronised level.

The core timer owns a toggle latch (`latch_o`). The latch inverts each time the core timer wraps in either direction. An auxiliary timer can stop counting and serve the core timer in one of two roles. As a capture register it snapshots the core value on a rising edge of its own pin. As a reload register it loads the core timer on its pin edge or on a chosen latch transition. If one auxiliary timer reloads on the latch rising and the other on the latch falling, `latch_o` becomes a free-running PWM whose high and low times are set by the two stored values. An auxiliary timer in counter mode can also count latch transitions instead of pin edges.

All ports are plain control and status pins. Nothing at the boundary streams data, so there is no valid/ready handshake. A single-cycle write port loads any timer.

Top module: `qtc_timer_group`

## Requirements
- R1: In mode 0 (timer) a running timer advances once per 2^(3+k) clock cycles, where k is its 3-bit `pre_sel_i` field. A timer with `run_i` low never counts in any mode.
- R2: In modes 0 to 2 the count goes down when `dir_down_i` XOR (`dir_ext_en_i` AND synchronised `tud_i`) is 1, and goes up otherwise.
- R3: In mode 1 (gated) the timer takes prescaled ticks only while synchronised `tin_i` equals `gate_lvl_i`.
- R4: In mode 2 (counter) the timer steps by exactly one per rising edge of `tin_i`. Pin levels are seen through two flops, so a pulse must last at least two clocks.
- R5: In mode 3 (encoder) `tin_i` is A and `tud_i` is B. Every single edge of A or B steps the count by one (4x decoding). The count goes up when A leads B, that is, for the sequence AB = 00,10,11,01, and down for the reverse. The direction bits have no effect in this mode.
- R6: A step from FFFF up or from 0000 down wraps and raises that timer's `wrap_o` bit for that one cycle. Only a core wrap inverts `latch_o`.
- R7: An auxiliary timer whose 2-bit `aux_role_i` field is 1 (capture), 2 (reload) or 3 (hold) does not count. Role 0 lets it count.
- R8: In capture role, a rising edge on the auxiliary timer's `tin_i` copies the current core value into that auxiliary timer.
- R9: In reload role, the 2-bit `rld_trig_i` field selects the event: 0 = rising edge of the auxiliary timer's own `tin_i`, 1 = latch rises, 2 = latch falls, 3 = either latch transition. On that event the core timer takes the auxiliary value in place of its stepped value. Auxiliary timer 0 has priority over auxiliary timer 1.
- R10: With auxiliary timer 0 reloading on the latch rising (value H), auxiliary timer 1 reloading on the latch falling (value L), and the core timer in timer mode counting up with prescale P, `latch_o` stays high for (10000h−H)·P cycles and low for (10000h−L)·P cycles, period after period.
- R11: An auxiliary timer in counter mode with its `aux_latch_clk_i` bit set counts every `latch_o` transition instead of pin edges.
- R12: `wr_en_i` loads `wr_data_i` into the timer numbered `wr_sel_i` (0 = core, 1 and 2 = auxiliary). The write takes effect on the next edge and overrides any step, capture or reload in that cycle.
- R13: After reset all counts are 0 and `latch_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tin_i | input | 3 | Per timer: clock, gate, encoder A or capture/reload trigger pin |
| tud_i | input | 3 | Per timer: direction pin or encoder B |
| run_i | input | 3 | Per timer run enable |
| mode_i | input | 6 | Per timer 2-bit mode: 0 timer, 1 gated, 2 counter, 3 encoder |
| pre_sel_i | input | 9 | Per timer 3-bit prescale select k |
| dir_down_i | input | 3 | Per timer software direction (1 = down) |
| dir_ext_en_i | input | 3 | Per timer: let `tud_i` invert the direction |
| gate_lvl_i | input | 3 | Per timer active gate level |
| aux_role_i | input | 4 | Per auxiliary timer role: 0 count, 1 capture, 2 reload, 3 hold |
| rld_trig_i | input | 4 | Per auxiliary timer reload event select |
| aux_latch_clk_i | input | 2 | Per auxiliary timer: counter mode counts latch transitions |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Timer index for the write |
| wr_data_i | input | 16 | Write value |
| cnt_o | output | 48 | Timer values, core in bits 15:0 |
| wrap_o | output | 3 | Per timer wrap pulse |
| latch_o | output | 1 | Core toggle latch |

## Verification
The prescaler is swept over all eight settings, and the count is checked over windows that are whole multiples of the tick period, so the prescaler phase cannot hide a wrong divide ratio. Counter mode gets bursts of one to five pulses. Encoder mode gets forward and reverse sequences of several lengths, which separates 4x decoding from 1x and 2x decoding and catches a swapped direction. The gated, direction-pin and run-low cases show whether the qualifiers are applied. Capture, pin reload with both auxiliary timers firing at once, reload on either latch transition combined with latch-clocked counting, and measured PWM high and low widths each tell apart which event selects which value.

// File: rtl/qtc_pkg.sv
package qtc_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER = 2'd0,
    MODE_GATED = 2'd1,
    MODE_COUNT = 2'd2,
    MODE_ENC   = 2'd3
  } qtc_mode_e;

  typedef enum logic [1:0] {
    ROLE_TIMER   = 2'd0,
    ROLE_CAPTURE = 2'd1,
    ROLE_RELOAD  = 2'd2,
    ROLE_HOLD    = 2'd3
  } qtc_role_e;

  typedef enum logic [1:0] {
    TRIG_PIN   = 2'd0,
    TRIG_LRISE = 2'd1,
    TRIG_LFALL = 2'd2,
    TRIG_LANY  = 2'd3
  } qtc_trig_e;
endpackage

// File: rtl/qtc_prescaler.sv
module qtc_prescaler #(
  parameter int BASE  = 3,
  parameter int SEL_W = 3,
  localparam int NSEL = 1 << SEL_W,
  localparam int CW   = BASE + NSEL - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NSEL-1:0] tick_o
);
  logic [CW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  // tick g fires once every 2^(BASE+g) cycles
  for (genvar g = 0; g < NSEL; g++) begin : g_tick
    assign tick_o[g] = &div_q[BASE+g-1:0];
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o[0] |=> !tick_o[0]);
endmodule

// File: rtl/qtc_pin_sync.sv
module qtc_pin_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/qtc_counter.sv
module qtc_counter
  import qtc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  qtc_mode_e    mode_i,
  input  logic         run_i,
  input  logic         stall_i,
  input  logic         tick_i,
  input  logic         in_lvl_i,
  input  logic         in_rise_i,
  input  logic         in_fall_i,
  input  logic         ud_lvl_i,
  input  logic         ud_rise_i,
  input  logic         ud_fall_i,
  input  logic         gate_lvl_i,
  input  logic         dir_down_i,
  input  logic         dir_ext_en_i,
  input  logic         alt_src_i,
  input  logic         alt_evt_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;
  logic step_raw, step, up, a_evt, b_evt, sw_down;

  always_comb begin
    a_evt    = in_rise_i | in_fall_i;
    b_evt    = ud_rise_i | ud_fall_i;
    sw_down  = dir_down_i ^ (dir_ext_en_i & ud_lvl_i);
    up       = ~sw_down;
    step_raw = 1'b0;
    case (mode_i)
      MODE_TIMER: step_raw = tick_i;
      MODE_GATED: step_raw = tick_i & (in_lvl_i == gate_lvl_i);
      MODE_COUNT: step_raw = alt_src_i ? alt_evt_i : in_rise_i;
      MODE_ENC: begin
        // simultaneous A and B edges are illegal and ignored
        step_raw = a_evt ^ b_evt;
        up       = a_evt ? (in_lvl_i != ud_lvl_i) : (ud_lvl_i == in_lvl_i);
      end
      default: step_raw = 1'b0;
    endcase
    step   = step_raw & run_i & ~stall_i;
    wrap_o = step & (up ? (&cnt_q) : ~(|cnt_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step) cnt_q <= up ? cnt_q + 1'b1 : cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

  // R4
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + W'(1)
                 || cnt_q == $past(cnt_q) - W'(1)));
  // R6
  wrap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_o && !load_i) |=> (cnt_q == '0 || cnt_q == '1));
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/qtc_timer_group.sv
module qtc_timer_group
  import qtc_pkg::*;
#(
  parameter int W         = 16,
  parameter int N_AUX     = 2,
  parameter int PRE_BASE  = 3,
  parameter int PRE_SEL_W = 3,
  localparam int NT       = N_AUX + 1,
  localparam int SW       = $clog2(NT),
  localparam int PSW      = PRE_SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NT-1:0]     tin_i,
  input  logic [NT-1:0]     tud_i,
  input  logic [NT-1:0]     run_i,
  input  logic [2*NT-1:0]   mode_i,
  input  logic [PSW*NT-1:0] pre_sel_i,
  input  logic [NT-1:0]     dir_down_i,
  input  logic [NT-1:0]     dir_ext_en_i,
  input  logic [NT-1:0]     gate_lvl_i,
  input  logic [2*N_AUX-1:0] aux_role_i,
  input  logic [2*N_AUX-1:0] rld_trig_i,
  input  logic [N_AUX-1:0]  aux_latch_clk_i,
  input  logic              wr_en_i,
  input  logic [SW-1:0]     wr_sel_i,
  input  logic [W-1:0]      wr_data_i,
  output logic [W*NT-1:0]   cnt_o,
  output logic [NT-1:0]     wrap_o,
  output logic              latch_o
);
  localparam int NSEL = 1 << PRE_SEL_W;

  logic [NSEL-1:0] tick_all;
  logic [NT-1:0] in_lvl, in_rise, in_fall, ud_lvl, ud_rise, ud_fall;
  logic [NT-1:0] wr_hit;
  logic [W-1:0]  core_cnt, core_load_val, rld_val;
  logic [W-1:0]  aux_cnt [N_AUX];
  logic          core_wrap_raw, core_wrap, core_load, rld_any, latch_q;
  logic [N_AUX-1:0] rld_fire, cap_fire;

  qtc_prescaler #(.BASE(PRE_BASE), .SEL_W(PRE_SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_o(tick_all));

  qtc_pin_sync #(.N(NT)) u_sync_in (
    .clk(clk), .rst_n(rst_n), .pin_i(tin_i),
    .lvl_o(in_lvl), .rise_o(in_rise), .fall_o(in_fall));

  qtc_pin_sync #(.N(NT)) u_sync_ud (
    .clk(clk), .rst_n(rst_n), .pin_i(tud_i),
    .lvl_o(ud_lvl), .rise_o(ud_rise), .fall_o(ud_fall));

  always_comb begin
    for (int t = 0; t < NT; t++) wr_hit[t] = wr_en_i && (wr_sel_i == SW'(t));
  end

  // core wrap is cancelled by a same-cycle write
  assign core_wrap = core_wrap_raw & ~wr_hit[0];

  // lowest-numbered auxiliary timer wins the reload
  always_comb begin
    rld_any = 1'b0;
    rld_val = '0;
    for (int i = N_AUX - 1; i >= 0; i--) begin
      if (rld_fire[i]) begin
        rld_any = 1'b1;
        rld_val = aux_cnt[i];
      end
    end
  end

  assign core_load     = wr_hit[0] | rld_any;
  assign core_load_val = wr_hit[0] ? wr_data_i : rld_val;

  qtc_counter #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .mode_i(qtc_mode_e'(mode_i[1:0])),
    .run_i(run_i[0]), .stall_i(1'b0),
    .tick_i(tick_all[pre_sel_i[PSW-1:0]]),
    .in_lvl_i(in_lvl[0]), .in_rise_i(in_rise[0]), .in_fall_i(in_fall[0]),
    .ud_lvl_i(ud_lvl[0]), .ud_rise_i(ud_rise[0]), .ud_fall_i(ud_fall[0]),
    .gate_lvl_i(gate_lvl_i[0]), .dir_down_i(dir_down_i[0]),
    .dir_ext_en_i(dir_ext_en_i[0]),
    .alt_src_i(1'b0), .alt_evt_i(1'b0),
    .load_i(core_load), .load_val_i(core_load_val),
    .cnt_o(core_cnt), .wrap_o(core_wrap_raw));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= 1'b0;
    else        latch_q <= latch_q ^ core_wrap;
  end

  assign latch_o      = latch_q;
  assign cnt_o[W-1:0] = core_cnt;
  assign wrap_o[0]    = core_wrap;

  for (genvar i = 0; i < N_AUX; i++) begin : g_aux
    qtc_role_e role;
    qtc_trig_e trig;
    logic      wrap_l, stall, load;
    logic [W-1:0] load_val;

    assign role  = qtc_role_e'(aux_role_i[2*i +: 2]);
    assign trig  = qtc_trig_e'(rld_trig_i[2*i +: 2]);
    assign stall = (role != ROLE_TIMER);

    assign rld_fire[i] = (role == ROLE_RELOAD) &&
      ((trig == TRIG_PIN)   ? in_rise[i+1] :
       (trig == TRIG_LRISE) ? (core_wrap & ~latch_q) :
       (trig == TRIG_LFALL) ? (core_wrap & latch_q) : core_wrap);
    assign cap_fire[i] = (role == ROLE_CAPTURE) && in_rise[i+1];

    assign load     = wr_hit[i+1] | cap_fire[i];
    assign load_val = wr_hit[i+1] ? wr_data_i : core_cnt;

    qtc_counter #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .mode_i(qtc_mode_e'(mode_i[2*(i+1) +: 2])),
      .run_i(run_i[i+1]), .stall_i(stall),
      .tick_i(tick_all[pre_sel_i[(i+1)*PSW +: PSW]]),
      .in_lvl_i(in_lvl[i+1]), .in_rise_i(in_rise[i+1]), .in_fall_i(in_fall[i+1]),
      .ud_lvl_i(ud_lvl[i+1]), .ud_rise_i(ud_rise[i+1]), .ud_fall_i(ud_fall[i+1]),
      .gate_lvl_i(gate_lvl_i[i+1]), .dir_down_i(dir_down_i[i+1]),
      .dir_ext_en_i(dir_ext_en_i[i+1]),
      .alt_src_i(aux_latch_clk_i[i]), .alt_evt_i(core_wrap),
      .load_i(load), .load_val_i(load_val),
      .cnt_o(aux_cnt[i]), .wrap_o(wrap_l));

    assign cnt_o[(i+1)*W +: W] = aux_cnt[i];
    assign wrap_o[i+1]         = wrap_l & ~wr_hit[i+1];

    // R8
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_fire[i] && !wr_hit[i+1]) |=> aux_cnt[i] == $past(core_cnt));
  end

  // R6
  latch_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(latch_q) |-> $past(core_wrap));
  // R9
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rld_any && !wr_hit[0]) |=> core_cnt == $past(rld_val));
  // R12
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[0] |=> core_cnt == $past(wr_data_i));
endmodule

// File: tb/test_qtc_timer_group.sv
module test_qtc_timer_group;
  localparam int W = 16, NT = 3, PSW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NT-1:0] tin = '0, tud = '0, run = '0, dir_down = '0, dir_ext = '0, gate_lvl = '0;
  logic [2*NT-1:0] mode = '0;
  logic [PSW*NT-1:0] pre_sel = '0;
  logic [3:0] aux_role = '0, rld_trig = '0;
  logic [1:0] aux_lclk = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic [W*NT-1:0] cnt_o;
  logic [NT-1:0] wrap_o;
  logic latch_o;

  int n_cmp = 0, n_bad = 0, wraps0 = 0, enc_st = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qtc_timer_group i_qtc_timer_group (
    .clk(clk), .rst_n(rst_n), .tin_i(tin), .tud_i(tud), .run_i(run),
    .mode_i(mode), .pre_sel_i(pre_sel), .dir_down_i(dir_down),
    .dir_ext_en_i(dir_ext), .gate_lvl_i(gate_lvl), .aux_role_i(aux_role),
    .rld_trig_i(rld_trig), .aux_latch_clk_i(aux_lclk), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .cnt_o(cnt_o), .wrap_o(wrap_o),
    .latch_o(latch_o));

  always @(posedge clk) if (rst_n && wrap_o[0]) wraps0++;

  function automatic logic [W-1:0] cnt(input int t);
    return cnt_o[t*W +: W];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int t, input logic [W-1:0] d);
    wr_en = 1'b1; wr_sel = 2'(t); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int t);
    tin[t] = 1'b1; cyc(4);
    tin[t] = 1'b0; cyc(4);
  endtask

  task automatic enc_step(input int d);
    enc_st = (enc_st + d) & 3;
    case (enc_st)
      0: begin tin[0] = 1'b0; tud[0] = 1'b0; end
      1: begin tin[0] = 1'b1; tud[0] = 1'b0; end
      2: begin tin[0] = 1'b1; tud[0] = 1'b1; end
      default: begin tin[0] = 1'b0; tud[0] = 1'b1; end
    endcase
    cyc(4);
  endtask

  task automatic count_while(input logic v, output int n);
    n = 0;
    while (latch_o === v && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v0;
    logic lat;
    int hi, lo, w0;
    cyc(5);
    rst_n = 1'b1;
    cyc(1);
    // R13 reset state
    for (int t = 0; t < NT; t++) chk("R13 count", {16'h0, cnt(t)}, 32'h0);
    chk("R13 latch", {31'h0, latch_o}, 32'h0);

    // R12 writes land in the selected timer, aux in hold role
    aux_role = 4'b1111;
    for (int t = 0; t < NT; t++) begin
      wr(t, 16'h1000 + 16'(t * 16'h111));
      chk("R12 write", {16'h0, cnt(t)}, {16'h0, 16'h1000 + 16'(t * 16'h111)});
    end
    run = 3'b111; pre_sel = '0;
    cyc(64);
    // R7 hold role keeps aux values
    chk("R7 hold aux1", {16'h0, cnt(1)}, 32'h1111);
    chk("R7 hold aux2", {16'h0, cnt(2)}, 32'h1222);
    // R12 write beats a running count
    wr(0, 16'h4242);
    chk("R12 write over count", {16'h0, cnt(0)}, 32'h4242);

    // R1 prescaler sweep on core and aux0
    aux_role = 4'b1100;
    for (int k = 0; k < 8; k++) begin
      pre_sel = 9'(k | (k << 3));
      cyc(2);
      v0 = cnt(0);
      w0 = cnt(1);
      cyc(4 << (3 + k));
      chk($sformatf("R1 core k=%0d", k), {16'h0, cnt(0) - v0}, 32'h4);
      chk($sformatf("R1 aux k=%0d", k), {16'h0, cnt(1) - 16'(w0)}, 32'h4);
    end
    pre_sel = '0;
    run[0] = 1'b0; v0 = cnt(0); cyc(64);
    chk("R1 run low", {16'h0, cnt(0)}, {16'h0, v0});
    run[0] = 1'b1;

    // R2 software and pin direction
    dir_down[0] = 1'b1; cyc(2); v0 = cnt(0); cyc(32);
    chk("R2 down", {16'h0, cnt(0) - v0}, 32'hFFFC);
    dir_ext[0] = 1'b1; tud[0] = 1'b1; cyc(6); v0 = cnt(0); cyc(32);
    chk("R2 pin inverts", {16'h0, cnt(0) - v0}, 32'h4);
    dir_ext[0] = 1'b0; dir_down[0] = 1'b0; tud[0] = 1'b0; cyc(6);

    // R3 gated
    mode[1:0] = 2'd1; gate_lvl[0] = 1'b1; tin[0] = 1'b0; cyc(6);
    v0 = cnt(0); cyc(64);
    chk("R3 gate closed", {16'h0, cnt(0) - v0}, 32'h0);
    tin[0] = 1'b1; cyc(6); v0 = cnt(0); cyc(64);
    chk("R3 gate open", {16'h0, cnt(0) - v0}, 32'h8);
    gate_lvl[0] = 1'b0; tin[0] = 1'b0; cyc(6); v0 = cnt(0); cyc(64);
    chk("R3 low-active gate", {16'h0, cnt(0) - v0}, 32'h8);

    // R4 counter bursts
    mode[1:0] = 2'd2; cyc(6);
    for (int n = 1; n <= 5; n++) begin
      v0 = cnt(0);
      for (int p = 0; p < n; p++) pulse(0);
      chk($sformatf("R4 burst %0d", n), {16'h0, cnt(0) - v0}, 32'(n));
    end
    dir_down[0] = 1'b1; v0 = cnt(0);
    for (int p = 0; p < 3; p++) pulse(0);
    chk("R4 down burst", {16'h0, cnt(0) - v0}, 32'hFFFD);
    dir_down[0] = 1'b0;
    run[0] = 1'b0; v0 = cnt(0); pulse(0);
    chk("R1 run low counter", {16'h0, cnt(0) - v0}, 32'h0);
    run[0] = 1'b1;

    // R5 encoder 4x decoding
    mode[1:0] = 2'd3; cyc(6);
    for (int k = 1; k <= 7; k += 2) begin
      v0 = cnt(0);
      for (int s = 0; s < k; s++) enc_step(1);
      chk($sformatf("R5 fwd %0d", k), {16'h0, cnt(0) - v0}, 32'(k));
      v0 = cnt(0);
      for (int s = 0; s < k + 1; s++) enc_step(-1);
      chk($sformatf("R5 rev %0d", k + 1), {16'h0, v0 - cnt(0)}, 32'(k + 1));
    end
    dir_down[0] = 1'b1; v0 = cnt(0);
    for (int s = 0; s < 4; s++) enc_step(1);
    chk("R5 dir bit ignored", {16'h0, cnt(0) - v0}, 32'h4);
    dir_down[0] = 1'b0;
    // R6 encoder underflow
    wr(0, 16'h0000); lat = latch_o; w0 = wraps0;
    enc_step(-1);
    chk("R6 underflow", {16'h0, cnt(0)}, 32'hFFFF);
    chk("R6 latch on underflow", {31'h0, latch_o}, {31'h0, ~lat});
    chk("R6 wrap pulse", 32'(wraps0 - w0), 32'h1);

    // R6 overflow in timer mode
    mode[1:0] = 2'd0; lat = latch_o;
    wr(0, 16'hFFFE); cyc(23);
    chk("R6 overflow", {16'h0, cnt(0)}, 32'h0001);
    chk("R6 latch on overflow", {31'h0, latch_o}, {31'h0, ~lat});
    // R6 aux wrap leaves latch alone
    dir_down[1] = 1'b1; lat = latch_o; run[0] = 1'b0;
    wr(1, 16'h0001); cyc(23);
    chk("R6 aux underflow", {16'h0, cnt(1)}, 32'hFFFE);
    chk("R6 aux wrap no latch", {31'h0, latch_o}, {31'h0, lat});
    dir_down[1] = 1'b0;

    // R8 capture and R7 stall while capturing
    wr(0, 16'h1234); aux_role = 4'b1101;
    v0 = cnt(1); cyc(64);
    chk("R7 capture role stalls", {16'h0, cnt(1)}, {16'h0, v0});
    pulse(1);
    chk("R8 capture", {16'h0, cnt(1)}, 32'h1234);

    // R9 pin reload and priority
    aux_role = 4'b1011; rld_trig = 4'b0000;
    wr(2, 16'hABCD); pulse(2);
    chk("R9 pin reload", {16'h0, cnt(0)}, 32'hABCD);
    aux_role = 4'b1010; wr(1, 16'h1111); wr(2, 16'h2222);
    tin[1] = 1'b1; tin[2] = 1'b1; cyc(4); tin[1] = 1'b0; tin[2] = 1'b0; cyc(4);
    chk("R9 aux0 priority", {16'h0, cnt(0)}, 32'h1111);

    // R9 reload on either transition, R11 latch-clocked aux0
    aux_role = 4'b1000; rld_trig = 4'b1100;
    mode = 6'b00_10_00; aux_lclk = 2'b01; run = 3'b011;
    wr(2, 16'hFFFC); wr(0, 16'hFFFC); wr(1, 16'h0000);
    cyc(100);
    v0 = cnt(1); w0 = wraps0;
    cyc(256);
    chk("R11 latch-clocked aux", {16'h0, cnt(1) - v0}, 32'h8);
    chk("R9 reload on any edge", 32'(wraps0 - w0), 32'h8);

    // R10 PWM with alternating reloads
    run = 3'b001; mode = '0; aux_lclk = '0;
    aux_role = 4'b1010; rld_trig = 4'b1001;
    wr(1, 16'hFFF0); wr(2, 16'hFFF8); wr(0, 16'hFFF8);
    for (int r = 0; r < 2; r++) begin
      count_while(1'b1, hi);
      count_while(1'b0, lo);
      count_while(1'b1, hi);
      chk("R10 high width", 32'(hi), 32'((17'h10000 - 17'hFFF0) * 8));
      count_while(1'b0, lo);
      chk("R10 low width", 32'(lo), 32'((17'h10000 - 17'hFFF8) * 8));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule